// File: doc/BRIEF.md
# Vector Length Set Unit

This unit executes the instruction that sets the maximum vector length and the active vector length of a 64-bit vector state register. Decode hands it the destination and first-source register numbers, a 7-bit immediate, the four mode flags and a one-cycle issue strobe. The register file supplies the first-source value, and the loop count register supplies its value. The state register is updated on the clock edge that takes the strobe. On the same edge the unit registers the new length for writeback to the destination register, and a summary-overflow bit for the condition register.

The new length comes from one of four places: the current state, the first-source register, the immediate, or the count register. The choice depends on the length-set flag and on whether the two register numbers are zero. The immediate is stored minus one. Register-sourced values above 127 saturate and raise overflow. The result is never larger than the maximum length. When neither length field is requested, the instruction only reads the current length back.

Top module: `vlset_unit`

## Requirements
- R1: Synchronous reset loads `state_q` with parameter `STATE_RESET` and holds `rt_we`, `cr_we` and `cr_so` low.
- R2: The immediate is biased: the value used is `imm + 1`. The 8-bit result 128 saturates to 127, because the length fields are 7 bits wide.
- R3: With `set_max`=1 the maximum-length field (`state_q[63:57]`) takes the biased immediate. With `set_max`=0 it keeps its value.
- R4: With `set_len`=0 the candidate length is the current length field (`state_q[56:50]`).
- R5: With `set_len`=1 and `ra_num`≠0 the candidate is `ra_val`. A value above 127 (unsigned) saturates to 127 and raises overflow.
- R6: With `set_len`=1 and `ra_num`=0, the candidate is the biased immediate when `rt_num`=0. When `rt_num`≠0 it is `cnt_val`, with the same saturation and overflow as in R5.
- R7: The final length is MIN(candidate, new maximum length). It is written to `state_q[56:50]` when `set_max` or `set_len` is 1.
- R8: On the edge after an issue, `rt_we` is 1 and `rt_data` holds the final length zero-extended to 64 bits. With no issue, `rt_we` is 0.
- R9: When `set_max` or `set_len` is 1, `state_q[0]` (vertical-first) takes `vfirst_req` and `state_q[1]` (remap persistence) is cleared. When both are 0, the whole state register is unchanged.
- R10: With `rc`=1, `cr_we` is 1 on the edge after issue and `cr_so` equals the overflow of R5/R6. With `rc`=0, `cr_we` and `cr_so` are 0. Overflow is never raised when `set_len`=0 or the immediate is the source.
- R11: `state_q[49:2]` never changes, and with no issue the whole state register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | One-cycle instruction strobe |
| rt_num | input | 5 | Destination register number |
| ra_num | input | 5 | First-source register number |
| imm | input | 7 | Biased length immediate |
| set_max | input | 1 | Write maximum length from immediate |
| set_len | input | 1 | Write length from selected source |
| vfirst_req | input | 1 | Requested vertical-first mode |
| rc | input | 1 | Record overflow into condition register |
| ra_val | input | 64 | First-source register value |
| cnt_val | input | 64 | Count register value |
| state_q | output | 64 | Vector state register |
| rt_data | output | 64 | Destination writeback value |
| rt_we | output | 1 | Destination write enable |
| cr_so | output | 1 | Summary-overflow bit |
| cr_we | output | 1 | Condition-register write enable |

## Verification
A wrong source choice or a missed clamp shows at the ports on the first edge after issue. `rt_data` and the length field of `state_q` then differ from the expected minimum. A corrupted maximum length, or a mode bit that was not cleared, sits silent in `state_q` until a later length-setting or read-back instruction uses it. Each directed scenario therefore compares the full state word after every instruction, not only the writeback. Untouched bits are seeded with a nonzero reset pattern, so that a stray write to them shows at once.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [1:0] {
    SRC_STATE = 2'd0,
    SRC_REG_A = 2'd1,
    SRC_IMM   = 2'd2,
    SRC_COUNT = 2'd3
  } len_src_e;

  typedef struct packed {
    logic set_max;
    logic set_len;
    logic vfirst;
    logic rc;
  } vls_ctl_t;
endpackage

// File: rtl/vls_imm_bias.sv
module vls_imm_bias #(
  parameter int LEN_W = 7
) (
  input  logic [LEN_W-1:0] imm,
  output logic [LEN_W-1:0] len
);
  logic [LEN_W:0] sum;

  always_comb begin
    sum = {1'b0, imm} + {{LEN_W{1'b0}}, 1'b1};
    if (sum[LEN_W]) len = {LEN_W{1'b1}};
    else            len = sum[LEN_W-1:0];
  end
endmodule

// File: rtl/vls_reg_sat.sv
module vls_reg_sat #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic [XLEN-1:0]  val,
  output logic [LEN_W-1:0] len,
  output logic             ovf
);
  always_comb begin
    ovf = |val[XLEN-1:LEN_W];
    len = ovf ? {LEN_W{1'b1}} : val[LEN_W-1:0];
  end
endmodule

// File: rtl/vls_src_sel.sv
module vls_src_sel
  import vls_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7,
  parameter int REG_W = 5
) (
  input  logic             set_len,
  input  logic [REG_W-1:0] rt_num,
  input  logic [REG_W-1:0] ra_num,
  input  logic [LEN_W-1:0] imm_len,
  input  logic [LEN_W-1:0] state_len,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  cnt_val,
  output len_src_e         src,
  output logic [LEN_W-1:0] len_raw,
  output logic             ovf
);
  localparam int NOPS = 2;

  logic [XLEN-1:0]  opnd     [NOPS];
  logic [LEN_W-1:0] opnd_len [NOPS];
  logic             opnd_ovf [NOPS];

  assign opnd[0] = ra_val;
  assign opnd[1] = cnt_val;

  for (genvar g = 0; g < NOPS; g++) begin : g_sat
    vls_reg_sat #(.XLEN(XLEN), .LEN_W(LEN_W)) u_sat (
      .val (opnd[g]),
      .len (opnd_len[g]),
      .ovf (opnd_ovf[g])
    );
  end

  always_comb begin
    if (!set_len)           src = SRC_STATE;
    else if (ra_num != '0)  src = SRC_REG_A;
    else if (rt_num == '0)  src = SRC_IMM;
    else                    src = SRC_COUNT;
  end

  always_comb begin
    len_raw = state_len;
    ovf     = 1'b0;
    unique case (src)
      SRC_STATE: len_raw = state_len;
      SRC_IMM:   len_raw = imm_len;
      SRC_REG_A: begin
        len_raw = opnd_len[0];
        ovf     = opnd_ovf[0];
      end
      SRC_COUNT: begin
        len_raw = opnd_len[1];
        ovf     = opnd_ovf[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vlset_unit.sv
module vlset_unit
  import vls_pkg::*;
#(
  parameter int             XLEN        = 64,
  parameter int             LEN_W       = 7,
  parameter int             REG_W       = 5,
  parameter logic [XLEN-1:0] STATE_RESET = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic [REG_W-1:0] rt_num,
  input  logic [REG_W-1:0] ra_num,
  input  logic [LEN_W-1:0] imm,
  input  logic             set_max,
  input  logic             set_len,
  input  logic             vfirst_req,
  input  logic             rc,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [XLEN-1:0]  cnt_val,
  output logic [XLEN-1:0]  state_q,
  output logic [XLEN-1:0]  rt_data,
  output logic             rt_we,
  output logic             cr_so,
  output logic             cr_we
);
  // Field positions counted from the least-significant bit
  localparam int MAX_HI  = XLEN - 1;
  localparam int MAX_LO  = XLEN - LEN_W;
  localparam int LEN_HI  = MAX_LO - 1;
  localparam int LEN_LO  = XLEN - 2 * LEN_W;
  localparam int PST_BIT = 1;
  localparam int VF_BIT  = 0;

  vls_ctl_t         ctl;
  len_src_e         src;
  logic [LEN_W-1:0] imm_len;
  logic [LEN_W-1:0] cur_max;
  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] new_max;
  logic [LEN_W-1:0] len_raw;
  logic [LEN_W-1:0] len_fin;
  logic             ovf;
  logic             wr_state;
  logic [XLEN-1:0]  state_d;

  assign ctl     = '{set_max: set_max, set_len: set_len, vfirst: vfirst_req, rc: rc};
  assign cur_max = state_q[MAX_HI:MAX_LO];
  assign cur_len = state_q[LEN_HI:LEN_LO];

  vls_imm_bias #(.LEN_W(LEN_W)) u_bias (
    .imm (imm),
    .len (imm_len)
  );

  vls_src_sel #(.XLEN(XLEN), .LEN_W(LEN_W), .REG_W(REG_W)) u_sel (
    .set_len   (ctl.set_len),
    .rt_num    (rt_num),
    .ra_num    (ra_num),
    .imm_len   (imm_len),
    .state_len (cur_len),
    .ra_val    (ra_val),
    .cnt_val   (cnt_val),
    .src       (src),
    .len_raw   (len_raw),
    .ovf       (ovf)
  );

  always_comb begin
    new_max  = ctl.set_max ? imm_len : cur_max;
    len_fin  = (len_raw > new_max) ? new_max : len_raw;
    wr_state = issue && (ctl.set_max || ctl.set_len);
    state_d  = state_q;
    state_d[MAX_HI:MAX_LO] = new_max;
    state_d[LEN_HI:LEN_LO] = len_fin;
    state_d[PST_BIT]       = 1'b0;
    state_d[VF_BIT]        = ctl.vfirst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= STATE_RESET;
      rt_data <= '0;
      rt_we   <= 1'b0;
      cr_so   <= 1'b0;
      cr_we   <= 1'b0;
    end else begin
      if (wr_state) state_q <= state_d;
      rt_we <= issue;
      cr_we <= issue && ctl.rc;
      cr_so <= issue && ctl.rc && ovf && (src != SRC_STATE);
      if (issue) rt_data <= {{(XLEN-LEN_W){1'b0}}, len_fin};
    end
  end
endmodule

// File: rtl/vlset_unit_chk.sv
module vlset_unit_chk #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            issue,
  input logic            set_max,
  input logic            set_len,
  input logic            vfirst_req,
  input logic [XLEN-1:0] state_q,
  input logic [XLEN-1:0] rt_data,
  input logic            rt_we,
  input logic            cr_so,
  input logic            cr_we
);
  localparam int MAX_LO = XLEN - LEN_W;
  localparam int LEN_LO = XLEN - 2 * LEN_W;

  // R8
  wb_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    rt_we |-> (rt_data[XLEN-1:LEN_W] == '0));

  // R7
  len_le_max_chk: assert property (@(posedge clk) disable iff (rst)
    rt_we |-> (rt_data[LEN_W-1:0] <= state_q[XLEN-1:MAX_LO]));

  // R7
  len_field_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && (set_max || set_len)) |=> (state_q[MAX_LO-1:LEN_LO] == rt_data[LEN_W-1:0]));

  // R9
  mode_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && (set_max || set_len)) |=> (state_q[1] == 1'b0 && state_q[0] == $past(vfirst_req)));

  // R9
  getlen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !set_max && !set_len) |=> $stable(state_q));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !issue |=> ($stable(state_q) && !rt_we && !cr_we));

  // R11
  mid_bits_chk: assert property (@(posedge clk) disable iff (rst)
    issue |=> $stable(state_q[LEN_LO-1:2]));

  // R10
  so_needs_we_chk: assert property (@(posedge clk) disable iff (rst)
    cr_so |-> cr_we);

  // R10
  getlen_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && !set_len) |=> !cr_so);
endmodule

bind vlset_unit vlset_unit_chk #(.XLEN(XLEN), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .issue      (issue),
  .set_max    (set_max),
  .set_len    (set_len),
  .vfirst_req (vfirst_req),
  .state_q    (state_q),
  .rt_data    (rt_data),
  .rt_we      (rt_we),
  .cr_so      (cr_so),
  .cr_we      (cr_we)
);

// File: tb/sim_vlset_unit.sv
module sim_vlset_unit;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 20000;
  localparam logic [63:0] RST_VAL = 64'h0003_1234_5678_9ABE;

  logic        clk = 1'b0;
  logic        rst;
  logic        issue;
  logic [4:0]  rt_num, ra_num;
  logic [6:0]  imm;
  logic        set_max, set_len, vfirst_req, rc;
  logic [63:0] ra_val, cnt_val;
  logic [63:0] state_q, rt_data;
  logic        rt_we, cr_so, cr_we;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [63:0] m_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlset_unit #(.STATE_RESET(RST_VAL)) u0 (
    .clk(clk), .rst(rst), .issue(issue), .rt_num(rt_num), .ra_num(ra_num),
    .imm(imm), .set_max(set_max), .set_len(set_len), .vfirst_req(vfirst_req),
    .rc(rc), .ra_val(ra_val), .cnt_val(cnt_val), .state_q(state_q),
    .rt_data(rt_data), .rt_we(rt_we), .cr_so(cr_so), .cr_we(cr_we)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] bias(input logic [6:0] f);
    return (f == 7'h7F) ? 7'h7F : f + 7'd1;
  endfunction

  // One instruction; expected results follow the requirement text
  task automatic do_op(input string tag, input bit ms, input bit vs, input bit vf,
                       input bit rcb, input logic [4:0] rt, input logic [4:0] ra,
                       input logic [6:0] im, input logic [63:0] rav, input logic [63:0] cv);
    logic [6:0] e_max, e_len;
    bit e_ovf;
    e_ovf = 0;
    e_max = ms ? bias(im) : m_state[63:57];
    if (!vs) e_len = m_state[56:50];
    else if (ra != 0) begin
      if (rav > 64'd127) begin e_len = 7'd127; e_ovf = 1; end
      else e_len = rav[6:0];
    end else if (rt == 0) e_len = bias(im);
    else begin
      if (cv > 64'd127) begin e_len = 7'd127; e_ovf = 1; end
      else e_len = cv[6:0];
    end
    if (e_len > e_max) e_len = e_max;
    if (ms || vs) begin
      m_state[63:57] = e_max;
      m_state[56:50] = e_len;
      m_state[1] = 1'b0;
      m_state[0] = vf;
    end
    @(negedge clk);
    issue = 1; set_max = ms; set_len = vs; vfirst_req = vf; rc = rcb;
    rt_num = rt; ra_num = ra; imm = im; ra_val = rav; cnt_val = cv;
    @(negedge clk);
    issue = 0;
    chk({tag, " rt_data"}, rt_data, {57'd0, e_len});
    chk({tag, " rt_we"}, {63'd0, rt_we}, 64'd1);
    chk({tag, " cr_we"}, {63'd0, cr_we}, {63'd0, rcb});
    chk({tag, " cr_so"}, {63'd0, cr_so}, {63'd0, rcb & e_ovf});
    chk({tag, " state"}, state_q, m_state);
  endtask

  task automatic t_reset();
    rst = 1; issue = 0; set_max = 0; set_len = 0; vfirst_req = 0; rc = 0;
    rt_num = 0; ra_num = 0; imm = 0; ra_val = 0; cnt_val = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_state = RST_VAL;
    chk("R1 state", state_q, RST_VAL);
    chk("R1 rt_we", {63'd0, rt_we}, 64'd0);
    chk("R1 cr_we", {63'd0, cr_we}, 64'd0);
  endtask

  task automatic t_set_max();
    do_op("R3 setmax 16", 1, 0, 1, 1, 0, 0, 7'd15, 0, 0);
    do_op("R2 max sat 127", 1, 0, 0, 0, 0, 0, 7'h7F, 0, 0);
    do_op("R3 setmax 32", 1, 0, 0, 0, 0, 0, 7'd31, 0, 0);
  endtask

  task automatic t_imm_len();
    do_op("R6 imm len 10", 0, 1, 1, 1, 0, 0, 7'd9, 0, 0);
    do_op("R7 imm clamp", 0, 1, 0, 0, 0, 0, 7'd60, 0, 0);
  endtask

  task automatic t_reg_a();
    do_op("R5 ra 12", 0, 1, 0, 1, 4, 3, 7'd0, 64'd12, 64'd99);
    do_op("R5 ra 0", 0, 1, 0, 0, 4, 3, 7'd0, 64'd0, 64'd99);
    do_op("R5 ra ovf", 0, 1, 1, 1, 0, 7, 7'd0, 64'd200, 64'd1);
    do_op("R10 ra ovf no rc", 0, 1, 0, 0, 0, 7, 7'd0, 64'd1 << 40, 64'd1);
  endtask

  task automatic t_count();
    do_op("R6 cnt 7", 0, 1, 0, 1, 5, 0, 7'd3, 64'd99, 64'd7);
    do_op("R6 cnt ovf", 0, 1, 0, 1, 5, 0, 7'd3, 64'd0, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_boundary();
    do_op("R5 ra 127 no ovf", 1, 1, 0, 1, 2, 9, 7'h7F, 64'd127, 64'd0);
    do_op("R5 ra 128 ovf", 0, 1, 0, 1, 2, 9, 7'd0, 64'd128, 64'd0);
    do_op("R4 keep len", 1, 0, 1, 1, 0, 0, 7'd3, 0, 0);
  endtask

  task automatic t_get_len();
    do_op("R9 get len", 0, 0, 1, 1, 6, 0, 7'd50, 64'd500, 64'd500);
    @(negedge clk);
    chk("R8 idle rt_we", {63'd0, rt_we}, 64'd0);
    chk("R11 idle state", state_q, m_state);
    chk("R11 mid bits", {16'd0, state_q[49:2]}, {16'd0, RST_VAL[49:2]});
  endtask

  initial begin
    t_reset();
    t_set_max();
    t_imm_len();
    t_reg_a();
    t_count();
    t_boundary();
    t_get_len();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (TIMEOUT) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule